// File: doc/BRIEF.md
# DDR3 Command Sequencer

This block sits on the controller side of a DDR3 memory and decides which abstract command goes to the memory in each clock cycle. The memory has 8 banks, 16384 rows and 128 columns. After reset it brings the memory up in a fixed order: an initialization phase, a long ZQ calibration and a leveling phase. It then raises its ready flag and serves traffic. The initialization and leveling phases each end when the single `phy_done` input is seen high. The PHY that does the real work is outside this block.

Each user access opens one row with an activate command. It then issues one or more read or write bursts. The column of each burst advances by the burst length, and the column wraps within the row. Finally it closes the bank with a precharge command. Between accesses the block serves maintenance work, and only when no row is open. That work is periodic refresh from an internal interval counter, self-refresh entry and exit, short ZQ calibration, and mode-register or multi-purpose-register access. Every minimum gap between commands is a parameter in clock cycles, and one shared down-counter enforces it.

Top module: `ddr3_cmd_seq`

## Requirements
- R1: After reset the command bus carries NOP (code 0) and `req_ready` stays low until `phy_done` is seen high. The next cycle carries ZQCL (code 7). `phy_done` is ignored until T_ZQL cycles after ZQCL. The first `phy_done` high after that point enters idle.
- R2: An accepted read is issued in this order: ACT (code 4) with `cmd_bank` set to the request bank and `cmd_addr` set to the row; then `req_bursts`+1 RD commands (code 6) to that bank; then PRE (code 3) to that bank.
- R3: An accepted write follows the same order as R2, with WR commands (code 5) in place of RD.
- R4: Burst k (counting from 0) carries the column (`req_col` + k·BL) mod 128 in the low 7 bits of `cmd_addr`, and the upper address bits are zero.
- R5: With `data_ok` high, these gaps between commands are exact:
  - the first burst comes T_RCD cycles after ACT;
  - bursts are T_CCD cycles apart;
  - PRE comes T_RTP cycles after the last RD, or T_WTP cycles after the last WR.
- R6: The next command comes no sooner than T_RP cycles after PRE, and no sooner than T_RFC cycles after REF. When the next command is waiting, it is issued exactly at that point.
- R7: While `data_ok` is low, no RD or WR is issued.
- R8: With no row open, REF (code 2, bank and address zero) is issued every REF_I cycles.
- R9: A refresh that falls due during an access is issued after that access's PRE and before any further ACT. No REF or maintenance command is issued while a row is open.
- R10: From idle, `mnt_sre` issues SRE (code 9). The block then issues nothing and keeps `req_ready` low until `mnt_srx`, which issues SRX (code 10). `mnt_srx` has no effect in idle.
- R11: From idle, these requests issue ZQCS (code 8), MRS (code 1) or MPR (code 11); MRS and MPR carry `mnt_bank` and `mnt_addr`. When several requests are present, the priority from highest is: pending refresh, self-refresh entry, ZQCS, MRS, MPR, user access.
- R12: `req_ready` is high only in idle, with the gap counter expired, no refresh pending and no maintenance request present. A request is accepted in the cycle its ACT is issued.
- R13: Every cycle that carries no command shows NOP. No command code appears in two consecutive cycles.
- R14: `op_done` pulses for one cycle with each PRE, REF, ZQCS, MRS, MPR and SRX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phy_done | input | 1 | Initialization or leveling step finished |
| req_valid | input | 1 | User access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Request bank |
| req_row | input | 14 | Request row |
| req_col | input | 7 | Start column |
| req_bursts | input | 3 | Number of bursts minus one |
| req_ready | output | 1 | Request accepted this cycle when `req_valid` is high |
| data_ok | input | 1 | Data path can move one burst |
| mnt_sre | input | 1 | Self-refresh entry request |
| mnt_srx | input | 1 | Self-refresh exit request |
| mnt_zqcs | input | 1 | Short calibration request (temperature or voltage change) |
| mnt_mrs | input | 1 | Mode-register set request |
| mnt_mpr | input | 1 | Multi-purpose-register access request |
| mnt_bank | input | 3 | Mode-register select for MRS/MPR |
| mnt_addr | input | 14 | Mode value for MRS/MPR |
| cmd_code | output | 4 | Command code |
| cmd_bank | output | 3 | Command bank |
| cmd_addr | output | 14 | Command row or column address |
| op_done | output | 1 | Operation completed pulse |

## Verification
The hardest case to reach from the ports is a refresh falling due while a long access is still open, with a second user request already waiting. The bench waits for an idle REF so that it knows the phase of the interval counter. Twenty cycles before the next refresh is due, it starts an eight-burst read and queues a second request at once. It then checks that REF lands exactly T_RP cycles after the first PRE, and that the second ACT follows exactly T_RFC cycles after REF. The bench also raises ZQCS, MRS and a user request in the same cycle to check the priority order.

// File: rtl/ddr3_seq_pkg.sv
package ddr3_seq_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_REF  = 4'd2,
    CMD_PRE  = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_WR   = 4'd5,
    CMD_RD   = 4'd6,
    CMD_ZQCL = 4'd7,
    CMD_ZQCS = 4'd8,
    CMD_SRE  = 4'd9,
    CMD_SRX  = 4'd10,
    CMD_MPR  = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_ZQCL,
    ST_LEVEL,
    ST_IDLE,
    ST_BURST,
    ST_PRE,
    ST_SREF
  } seq_state_e;

endpackage

// File: rtl/ddr3_gap_timer.sv
module ddr3_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en  = load || (cnt_q != '0);
  assign cnt_d   = load ? load_val : cnt_q - 1'b1;
  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ddr3_ref_tick.sv
module ddr3_ref_tick #(
  parameter int INTERVAL = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic pending
);

  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;
  logic          pend_q;

  assign tick    = (cnt_q == LAST);
  assign pending = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      pend_q <= tick || (pend_q && !clear);
    end
  end

endmodule

// File: rtl/ddr3_cmd_seq.sv
module ddr3_cmd_seq
  import ddr3_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 7,
  parameter int BCNT_W = 3,
  parameter int BL     = 8,
  parameter int TMR_W  = 8,
  parameter int T_RCD  = 4,
  parameter int T_CCD  = 4,
  parameter int T_RTP  = 3,
  parameter int T_WTP  = 6,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  parameter int T_ZQL  = 20,
  parameter int T_ZQS  = 6,
  parameter int T_MOD  = 4,
  parameter int T_XS   = 8,
  parameter int REF_I  = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_done,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BCNT_W-1:0] req_bursts,
  output logic              req_ready,
  input  logic              data_ok,
  input  logic              mnt_sre,
  input  logic              mnt_srx,
  input  logic              mnt_zqcs,
  input  logic              mnt_mrs,
  input  logic              mnt_mpr,
  input  logic [BANK_W-1:0] mnt_bank,
  input  logic [ROW_W-1:0]  mnt_addr,
  output logic [3:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic              op_done
);

  // Timer reload values: a gap of G cycles reloads G-1.
  localparam logic [TMR_W-1:0] LD_RCD = TMR_W'(T_RCD - 1);
  localparam logic [TMR_W-1:0] LD_CCD = TMR_W'(T_CCD - 1);
  localparam logic [TMR_W-1:0] LD_RTP = TMR_W'(T_RTP - 1);
  localparam logic [TMR_W-1:0] LD_WTP = TMR_W'(T_WTP - 1);
  localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] LD_RFC = TMR_W'(T_RFC - 1);
  localparam logic [TMR_W-1:0] LD_ZQL = TMR_W'(T_ZQL - 1);
  localparam logic [TMR_W-1:0] LD_ZQS = TMR_W'(T_ZQS - 1);
  localparam logic [TMR_W-1:0] LD_MOD = TMR_W'(T_MOD - 1);
  localparam logic [TMR_W-1:0] LD_XS  = TMR_W'(T_XS - 1);
  localparam logic [COL_W-1:0] COL_STEP = COL_W'(BL);

  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [BCNT_W-1:0] left_q;
  logic              wr_q;
  logic              latch_en, step_en;
  logic              tmr_load, tmr_expired;
  logic [TMR_W-1:0]  tmr_val;
  logic              ref_pend, ref_clr;
  logic              mnt_any;
  logic [ROW_W-1:0]  col_addr;
  cmd_e              cmd_d;

  ddr3_gap_timer #(.W(TMR_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  ddr3_ref_tick #(.INTERVAL(REF_I)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ref_clr),
    .pending (ref_pend)
  );

  // Column field placed in the low bits of the address bus.
  generate
    if (ROW_W > COL_W) begin : g_col_pad
      assign col_addr = {{(ROW_W-COL_W){1'b0}}, col_q};
    end else begin : g_col_trunc
      assign col_addr = col_q[ROW_W-1:0];
    end
  endgenerate

  assign mnt_any   = mnt_sre || mnt_zqcs || mnt_mrs || mnt_mpr;
  assign req_ready = (state_q == ST_IDLE) && tmr_expired && !ref_pend && !mnt_any;
  assign cmd_code  = cmd_d;

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    cmd_bank = '0;
    cmd_addr = '0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_clr  = 1'b0;
    op_done  = 1'b0;
    latch_en = 1'b0;
    step_en  = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        if (phy_done) state_d = ST_ZQCL;
      end
      ST_ZQCL: begin
        cmd_d    = CMD_ZQCL;
        tmr_load = 1'b1;
        tmr_val  = LD_ZQL;
        state_d  = ST_LEVEL;
      end
      ST_LEVEL: begin
        if (tmr_expired && phy_done) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (tmr_expired) begin
          if (ref_pend) begin
            cmd_d    = CMD_REF;
            ref_clr  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = LD_RFC;
            op_done  = 1'b1;
          end else if (mnt_sre) begin
            cmd_d   = CMD_SRE;
            state_d = ST_SREF;
          end else if (mnt_zqcs) begin
            cmd_d    = CMD_ZQCS;
            tmr_load = 1'b1;
            tmr_val  = LD_ZQS;
            op_done  = 1'b1;
          end else if (mnt_mrs || mnt_mpr) begin
            cmd_d    = mnt_mrs ? CMD_MRS : CMD_MPR;
            cmd_bank = mnt_bank;
            cmd_addr = mnt_addr;
            tmr_load = 1'b1;
            tmr_val  = LD_MOD;
            op_done  = 1'b1;
          end else if (req_valid) begin
            cmd_d    = CMD_ACT;
            cmd_bank = req_bank;
            cmd_addr = req_row;
            tmr_load = 1'b1;
            tmr_val  = LD_RCD;
            latch_en = 1'b1;
            state_d  = ST_BURST;
          end
        end
      end
      ST_BURST: begin
        if (tmr_expired && data_ok) begin
          cmd_d    = wr_q ? CMD_WR : CMD_RD;
          cmd_bank = bank_q;
          cmd_addr = col_addr;
          step_en  = 1'b1;
          tmr_load = 1'b1;
          if (left_q == '0) begin
            tmr_val = wr_q ? LD_WTP : LD_RTP;
            state_d = ST_PRE;
          end else begin
            tmr_val = LD_CCD;
          end
        end
      end
      ST_PRE: begin
        if (tmr_expired) begin
          cmd_d    = CMD_PRE;
          cmd_bank = bank_q;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
          op_done  = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_SREF: begin
        if (mnt_srx) begin
          cmd_d    = CMD_SRX;
          tmr_load = 1'b1;
          tmr_val  = LD_XS;
          op_done  = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      bank_q  <= '0;
      col_q   <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (latch_en) begin
        bank_q <= req_bank;
        col_q  <= req_col;
        left_q <= req_bursts;
        wr_q   <= req_write;
      end else if (step_en) begin
        col_q  <= col_q + COL_STEP;
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr3_cmd_seq_chk.sv
module ddr3_cmd_seq_chk
  import ddr3_seq_pkg::*;
#(
  parameter int T_RCD = 4,
  parameter int T_RP  = 3,
  parameter int T_RFC = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd_code,
  input logic       req_ready
);

  logic [15:0] since_act, since_pre, since_ref;
  logic        row_open, init_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      since_ref <= '1;
      row_open  <= 1'b0;
      init_seen <= 1'b0;
    end else begin
      since_act <= (cmd_code == CMD_ACT) ? 16'd1 : (since_act == '1 ? since_act : since_act + 16'd1);
      since_pre <= (cmd_code == CMD_PRE) ? 16'd1 : (since_pre == '1 ? since_pre : since_pre + 16'd1);
      since_ref <= (cmd_code == CMD_REF) ? 16'd1 : (since_ref == '1 ? since_ref : since_ref + 16'd1);
      if (cmd_code == CMD_ACT) row_open <= 1'b1;
      else if (cmd_code == CMD_PRE) row_open <= 1'b0;
      if (cmd_code == CMD_ZQCL) init_seen <= 1'b1;
    end
  end

  assert_rw_after_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> (since_act >= 16'(T_RCD)));

  assert_rw_row_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> row_open);

  assert_pre_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT || cmd_code == CMD_REF) |-> (since_pre >= 16'(T_RP)));

  assert_ref_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != CMD_NOP) |-> (since_ref >= 16'(T_RFC)));

  assert_closed_for_maint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_REF || cmd_code == CMD_SRE || cmd_code == CMD_ZQCS ||
     cmd_code == CMD_MRS || cmd_code == CMD_MPR || cmd_code == CMD_ACT) |-> !row_open);

  assert_act_after_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT) |-> init_seen);

  assert_ready_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_code == CMD_NOP || cmd_code == CMD_ACT));

  assert_single_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != CMD_NOP) |=> (cmd_code == CMD_NOP || cmd_code != $past(cmd_code)));

endmodule

bind ddr3_cmd_seq ddr3_cmd_seq_chk #(
  .T_RCD (T_RCD),
  .T_RP  (T_RP),
  .T_RFC (T_RFC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_code  (cmd_code),
  .req_ready (req_ready)
);

// File: tb/ddr3_cmd_seq_bench.sv
`timescale 1ns/1ps
module ddr3_cmd_seq_bench;

  localparam int T_RCD = 4, T_CCD = 4, T_RTP = 3, T_WTP = 6, T_RP = 3;
  localparam int T_RFC = 10, T_ZQL = 20, REF_I = 300;
  localparam int WD = 20000;
  localparam logic [3:0] NOP = 0, MRS = 1, REF = 2, PRE = 3, ACT = 4, WR = 5, RD = 6,
                         ZQCL = 7, ZQCS = 8, SRE = 9, SRX = 10, MPR = 11;

  typedef struct {
    logic [3:0]  c;
    logic [2:0]  b;
    logic [13:0] a;
    int          gap;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, phy_done, req_valid, req_write, data_ok;
  logic [2:0] req_bank, req_bursts, mnt_bank, cmd_bank;
  logic [13:0] req_row, mnt_addr, cmd_addr;
  logic [6:0] req_col;
  logic req_ready, mnt_sre, mnt_srx, mnt_zqcs, mnt_mrs, mnt_mpr, op_done;
  logic [3:0] cmd_code;

  int cyc = 0, checks = 0, errors = 0;
  int prev_cyc = 0, last_pre = 0, last_act = 0, pre_before_act = 0;
  int ref_cnt = 0, wr_cnt = 0, done_cnt = 0, exp_done = 0;
  int ref_q[$];
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  ddr3_cmd_seq #(.T_RCD(T_RCD), .T_CCD(T_CCD), .T_RTP(T_RTP), .T_WTP(T_WTP), .T_RP(T_RP),
                 .T_RFC(T_RFC), .T_ZQL(T_ZQL), .REF_I(REF_I)) u_ddr3_cmd_seq (
    .clk(clk), .rst_n(rst_n), .phy_done(phy_done),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_bursts(req_bursts), .req_ready(req_ready), .data_ok(data_ok),
    .mnt_sre(mnt_sre), .mnt_srx(mnt_srx), .mnt_zqcs(mnt_zqcs), .mnt_mrs(mnt_mrs),
    .mnt_mpr(mnt_mpr), .mnt_bank(mnt_bank), .mnt_addr(mnt_addr),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .op_done(op_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic void push(input logic [3:0] c, input logic [2:0] b, input logic [13:0] a,
                               input int gap, input string tag);
    item_t it;
    it.c = c; it.b = b; it.a = a; it.gap = gap; it.tag = tag;
    exp_q.push_back(it);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      chk(1'b0, "watchdog", cyc, WD);
      finish_run();
    end
  end

  // Monitor: pops the scoreboard on every command except REF, which it logs.
  always @(negedge clk) begin
    if (rst_n) begin
      if (op_done) done_cnt++;
      if (cmd_code != NOP) begin
        if (cmd_code == REF) begin
          ref_q.push_back(cyc);
          ref_cnt++;
          chk(cmd_bank == 0 && cmd_addr == 0, "R8 REF fields", {cmd_bank, cmd_addr}, 0);
        end else if (exp_q.size() == 0) begin
          chk(1'b0, "R13 unexpected command", cmd_code, NOP);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(cmd_code == it.c, {it.tag, " code"}, cmd_code, it.c);
          chk(cmd_bank == it.b, {it.tag, " bank"}, cmd_bank, it.b);
          chk(cmd_addr == it.a, {it.tag, " addr"}, cmd_addr, it.a);
          if (it.gap != 0) chk(cyc - prev_cyc == it.gap, {it.tag, " gap"}, cyc - prev_cyc, it.gap);
        end
        if (cmd_code == WR) wr_cnt++;
        if (cmd_code == PRE) last_pre = cyc;
        if (cmd_code == ACT) begin last_act = cyc; pre_before_act = last_pre; end
        prev_cyc = cyc;
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(posedge clk);
    cycles(12);
  endtask

  task automatic user_access(input logic wr, input logic [2:0] b, input logic [13:0] r,
                             input logic [6:0] c, input logic [2:0] n, input bit exact,
                             input string tag);
    push(ACT, b, r, 0, tag);
    for (int k = 0; k <= int'(n); k++) begin
      logic [6:0] cc;
      int g;
      cc = c + 7'(k * 8);
      g = (k == 0) ? (exact ? T_RCD : 0) : T_CCD;
      push(wr ? WR : RD, b, {7'd0, cc}, g, tag);
    end
    push(PRE, b, 14'd0, wr ? T_WTP : T_RTP, tag);
    exp_done++;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_bank = b; req_row = r; req_col = c; req_bursts = n;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Hold a maintenance request until its command appears.
  task automatic maint(input logic [3:0] c, input string tag);
    push(c, (c == MRS || c == MPR) ? mnt_bank : 3'd0, (c == MRS || c == MPR) ? mnt_addr : 14'd0, 0, tag);
    if (c != SRE) exp_done++;
    @(posedge clk); #1;
    case (c)
      SRE: mnt_sre = 1'b1;
      SRX: mnt_srx = 1'b1;
      ZQCS: mnt_zqcs = 1'b1;
      MRS: mnt_mrs = 1'b1;
      default: mnt_mpr = 1'b1;
    endcase
    do @(negedge clk); while (cmd_code != c);
    @(posedge clk); #1;
    mnt_sre = 0; mnt_srx = 0; mnt_zqcs = 0; mnt_mrs = 0; mnt_mpr = 0;
  endtask

  initial begin
    rst_n = 0; phy_done = 0; req_valid = 0; req_write = 0; data_ok = 1;
    req_bank = 0; req_row = 0; req_col = 0; req_bursts = 0;
    mnt_sre = 0; mnt_srx = 0; mnt_zqcs = 0; mnt_mrs = 0; mnt_mpr = 0;
    mnt_bank = 0; mnt_addr = 0;
    cycles(5);
    rst_n = 1;

    // R1 power-up order
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(cmd_code == NOP && !req_ready, "R1 before init done", {cmd_code, req_ready}, 0);
    end
    push(ZQCL, 0, 0, 0, "R1 ZQCL");
    @(posedge clk); #1 phy_done = 1;
    @(posedge clk); #1 phy_done = 0;
    cycles(8);
    phy_done = 1; @(posedge clk); #1 phy_done = 0;
    @(negedge clk);
    chk(!req_ready, "R1 early done ignored", req_ready, 0);
    drain();
    cycles(15);
    @(negedge clk);
    chk(!req_ready, "R1 leveling waits done", req_ready, 0);
    @(posedge clk); #1 phy_done = 1;
    @(posedge clk); #1 phy_done = 0;
    @(negedge clk);
    chk(req_ready, "R12 ready in idle", req_ready, 1);
    chk(cmd_code == NOP, "R13 NOP when idle", cmd_code, NOP);

    // R2 R4 R5 read, column wrap
    user_access(1'b0, 3'd5, 14'h2AAA, 7'h7C, 3'd2, 1'b1, "R2 R4 R5 read");
    drain();
    // R3 R5 write
    user_access(1'b1, 3'd0, 14'h3FFF, 7'h00, 3'd0, 1'b1, "R3 R5 write");
    drain();

    // R7 data_ok gating
    begin
      int w0;
      w0 = wr_cnt;
      data_ok = 0;
      user_access(1'b1, 3'd7, 14'h0123, 7'h10, 3'd1, 1'b0, "R7 held write");
      cycles(15);
      chk(wr_cnt == w0, "R7 no WR while data_ok low", wr_cnt, w0);
      data_ok = 1;
      drain();
      chk(wr_cnt == w0 + 2, "R7 WR after data_ok", wr_cnt, w0 + 2);
    end

    // R11 R12 priority ZQCS > MRS > user
    mnt_bank = 3'd2; mnt_addr = 14'h1234;
    push(ZQCS, 0, 0, 0, "R11 ZQCS first");
    push(MRS, 3'd2, 14'h1234, 0, "R11 MRS second");
    push(ACT, 3'd1, 14'h0042, 0, "R11 user last");
    push(RD, 3'd1, 14'h0003, T_RCD, "R11 user last");
    push(PRE, 3'd1, 14'd0, T_RTP, "R11 user last");
    exp_done += 3;
    @(posedge clk); #1;
    mnt_zqcs = 1; mnt_mrs = 1;
    req_valid = 1; req_write = 0; req_bank = 3'd1; req_row = 14'h0042; req_col = 7'h03; req_bursts = 0;
    begin
      bit first;
      first = 1;
      while (mnt_zqcs || mnt_mrs || req_valid) begin
        bit dz, dm, dv;
        @(negedge clk);
        if (first) chk(!req_ready, "R12 ready low with maintenance", req_ready, 0);
        first = 0;
        dz = (cmd_code == ZQCS); dm = (cmd_code == MRS); dv = (cmd_code == ACT);
        @(posedge clk); #1;
        if (dz) mnt_zqcs = 0;
        if (dm) mnt_mrs = 0;
        if (dv) req_valid = 0;
      end
    end
    drain();

    // R11 MPR
    mnt_bank = 3'd3; mnt_addr = 14'h0004;
    maint(MPR, "R11 MPR");
    drain();

    // R10 self-refresh
    @(posedge clk); #1 mnt_srx = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(cmd_code != SRX, "R10 exit ignored in idle", cmd_code, NOP);
    end
    @(posedge clk); #1 mnt_srx = 0;
    maint(SRE, "R10 SRE");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(cmd_code == NOP && !req_ready, "R10 quiet in self-refresh", {cmd_code, req_ready}, 0);
    end
    maint(SRX, "R10 SRX");
    drain();
    user_access(1'b0, 3'd4, 14'h0777, 7'h20, 3'd0, 1'b1, "R10 access after exit");
    drain();

    // R8 periodic refresh in idle
    begin
      int n0;
      n0 = ref_cnt;
      while (ref_cnt < n0 + 2) @(posedge clk);
      chk(ref_q[$] - ref_q[$-1] == REF_I, "R8 refresh period", ref_q[$] - ref_q[$-1], REF_I);
    end

    // R9 R6 refresh due during an access with a second request waiting
    begin
      int l, n0;
      l = ref_q[$];
      n0 = ref_cnt;
      while (cyc < l + REF_I - 20) @(posedge clk);
      user_access(1'b0, 3'd6, 14'h1111, 7'h00, 3'd7, 1'b1, "R9 long read");
      user_access(1'b1, 3'd2, 14'h2222, 7'h08, 3'd0, 1'b1, "R9 next write");
      drain();
      chk(ref_cnt == n0 + 1, "R9 one refresh", ref_cnt, n0 + 1);
      chk(ref_q[$] > pre_before_act && ref_q[$] < last_act, "R9 REF between PRE and ACT",
          ref_q[$], pre_before_act);
      chk(ref_q[$] - pre_before_act == T_RP, "R6 REF after PRE", ref_q[$] - pre_before_act, T_RP);
      chk(last_act - ref_q[$] == T_RFC, "R6 ACT after REF", last_act - ref_q[$], T_RFC);
    end

    chk(exp_q.size() == 0, "R13 scoreboard empty", exp_q.size(), 0);
    chk(done_cnt == exp_done + ref_cnt, "R14 done pulses", done_cnt, exp_done + ref_cnt);
    finish_run();
  end

endmodule